// File: doc/BRIEF.md
# Ring slave tag processor

This block is one slave node on a one-way ring of 64-bit tags. Each tag that arrives is registered and sent on downstream exactly one clock later. While it passes, the node reads the class and type fields to decide whether the tag concerns it. Tags that concern the node are pushed into a small queue. A decode stage drains that queue: command tags load a local DMA descriptor (source buffer address plus destination identifier) through a valid/ready handshake, and message tags raise a one-cycle flush pulse or a select pulse that carries a mode value.

The forwarded copy is rewritten according to class rules. A free (invalid, consumable) slot may carry a pending local message addressed to the scheduler. An accepted command has its done counter incremented. Messages bound for the scheduler, reserved classes and refused commands are passed on bit for bit. Whenever a field changes, the check code is recomputed.

Tag layout, MSB first: class [63:62], type [61:60], opcode [59:57], first flag [56], force flag [55], done flag [54], buffer address [53:43], identifier [42:31], done count [30:24], source node [23:17], info [16:10], reserved [9:7], check code [6:0]. Check code bit j is the XOR of every tag bit i in 7..63 for which (i-7) mod 7 = j.

Top module: `tagring_slave`

## Requirements
- R1: `out_vld_o` equals `tag_vld_i` delayed by one clock, and is low after reset. Unless a later rule changes a tag, `out_tag_o` is the input tag unchanged, one clock later.
- R2: Class 01 (message to scheduler) and class 11 (reserved) are forwarded unchanged and trigger no local action.
- R3: When a class 00 tag arrives while `msg_req_i` is high, it is replaced by a tag with these fields: class 01, type 11, opcode `msg_op_i`, info `msg_info_i`, source node `node_id_i`, every other field zero, and a fresh check code. `msg_ack_o` pulses in the same cycle that tag is output. A class 00 tag that arrives while `msg_req_i` is low is forwarded unchanged.
- R4: A class 10 type 00 command is accepted when the queue is not full and `dma_busy_i` is low. It is then queued, and it is forwarded with its done count incremented modulo 128 and a new check code.
- R5: A command that arrives while `dma_busy_i` is high, or while the queue holds FIFO_DEPTH entries, is forwarded unchanged and produces no DMA request.
- R6: A queued command drives `dma_vld_o` with `dma_src_o` = buffer address and `dma_dst_o` = identifier. Both are held stable until `dma_rdy_i` is seen high.
- R7: A class 10 type 01 (broadcast) message with opcode 100 produces a one-cycle `flush_o` pulse. Other broadcast opcodes produce no pulse.
- R8: A class 10 type 10 (directed) message acts only when identifier bits [6:0] equal `node_id_i`. Opcode 100 then pulses `flush_o`, and opcode 000 pulses `sel_o` with `mode_o` = info. A directed message with a different identifier has no effect.
- R9: Actions are carried out in arrival order. When the queue is empty and `dma_rdy_i` is high, an action appears exactly one cycle after its tag is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| node_id_i | input | 7 | Identifier of this node |
| tag_vld_i | input | 1 | Incoming tag valid |
| tag_i | input | 64 | Incoming tag |
| out_vld_o | output | 1 | Outgoing tag valid |
| out_tag_o | output | 64 | Outgoing tag |
| msg_req_i | input | 1 | Local message waiting for a free slot |
| msg_op_i | input | 3 | Opcode of the local message |
| msg_info_i | input | 7 | Info of the local message |
| msg_ack_o | output | 1 | Local message inserted |
| dma_busy_i | input | 1 | DMA engine cannot take a command |
| dma_vld_o | output | 1 | DMA descriptor valid |
| dma_rdy_i | input | 1 | DMA engine takes the descriptor |
| dma_src_o | output | 11 | Source buffer address |
| dma_dst_o | output | 12 | Destination identifier |
| flush_o | output | 1 | Flush pulse |
| sel_o | output | 1 | Mode select pulse |
| mode_o | output | 7 | Selected mode |

## Verification
The bench first runs a directed sequence with the DMA ready held low. This fills the queue, so refusal because the queue is full can be told apart from refusal because the engine is busy, and it shows that the descriptor is held until the engine takes it. A randomized run then mixes all classes, types and opcodes. Half of its identifiers match the node, so directed messages for this node are distinguished from those for other nodes. Local message requests arrive at random, which checks that only free slots carry inserted messages. In that run an action queue predicted from the tags is compared with the outputs each cycle, which exposes reordering, spurious actions and wrong latency.

// File: rtl/tagring_pkg.sv
package tagring_pkg;
  localparam int TAG_W  = 64;
  localparam int ADDR_W = 11;
  localparam int IDENT_W = 12;
  localparam int NODE_W = 7;
  localparam int CHK_W  = 7;

  typedef enum logic [1:0] {
    CLS_FREE  = 2'b00,
    CLS_SCHED = 2'b01,
    CLS_VALID = 2'b10,
    CLS_RSV   = 2'b11
  } tag_cls_e;

  typedef enum logic [1:0] {
    TYP_CMD      = 2'b00,
    TYP_BCAST    = 2'b01,
    TYP_DIRECT   = 2'b10,
    TYP_TO_SCHED = 2'b11
  } tag_typ_e;

  localparam logic [2:0] OP_FLUSH  = 3'b100;
  localparam logic [2:0] OP_SELECT = 3'b000;

  typedef struct packed {
    tag_cls_e             cls;
    tag_typ_e             typ;
    logic [2:0]           op;
    logic                 first_f;
    logic                 frc_f;
    logic                 done_f;
    logic [ADDR_W-1:0]    buf_addr;
    logic [IDENT_W-1:0]   ident;
    logic [6:0]           dcnt;
    logic [NODE_W-1:0]    src_id;
    logic [6:0]           info;
    logic [2:0]           rsv;
    logic [CHK_W-1:0]     chk;
  } tag_t;

  function automatic logic [CHK_W-1:0] chk_calc(input tag_t t);
    logic [TAG_W-1:0] v;
    logic [CHK_W-1:0] c;
    v = t;
    c = '0;
    for (int i = CHK_W; i < TAG_W; i++) c[(i-CHK_W)%CHK_W] ^= v[i];
    return c;
  endfunction
endpackage

// File: rtl/tagring_classify.sv
module tagring_classify
  import tagring_pkg::*;
(
  input  tag_t              tag_i,
  input  logic [NODE_W-1:0] node_id_i,
  input  logic              fifo_full_i,
  input  logic              dma_busy_i,
  input  logic              msg_req_i,
  input  logic [2:0]        msg_op_i,
  input  logic [6:0]        msg_info_i,
  output tag_t              fwd_o,
  output logic              push_o,
  output logic              ins_o
);
  tag_t t;

  always_comb begin
    t      = tag_i;
    push_o = 1'b0;
    ins_o  = 1'b0;
    unique case (tag_i.cls)
      CLS_FREE: begin
        if (msg_req_i) begin
          ins_o    = 1'b1;
          t        = '0;
          t.cls    = CLS_SCHED;
          t.typ    = TYP_TO_SCHED;
          t.op     = msg_op_i;
          t.info   = msg_info_i;
          t.src_id = node_id_i;
          t.chk    = chk_calc(t);
        end
      end
      CLS_VALID: begin
        unique case (tag_i.typ)
          TYP_CMD: begin
            if (!fifo_full_i && !dma_busy_i) begin
              push_o = 1'b1;
              t.dcnt = tag_i.dcnt + 7'd1;
              t.chk  = chk_calc(t);
            end
          end
          TYP_BCAST:  push_o = !fifo_full_i;
          TYP_DIRECT: push_o = !fifo_full_i && (tag_i.ident[NODE_W-1:0] == node_id_i);
          default: ;
        endcase
      end
      default: ;
    endcase
    fwd_o = t;
  end
endmodule

// File: rtl/tagring_fifo.sv
module tagring_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem_q[rp_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + AW'(1);
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + AW'(1);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/tagring_exec.sv
module tagring_exec
  import tagring_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  tag_t               head_i,
  input  logic               empty_i,
  output logic               pop_o,
  output logic               dma_vld_o,
  input  logic               dma_rdy_i,
  output logic [ADDR_W-1:0]  dma_src_o,
  output logic [IDENT_W-1:0] dma_dst_o,
  output logic               flush_o,
  output logic               sel_o,
  output logic [6:0]         mode_o
);
  // a held descriptor blocks the queue until taken
  assign pop_o = !empty_i && (!dma_vld_o || dma_rdy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_vld_o <= 1'b0;
      dma_src_o <= '0;
      dma_dst_o <= '0;
      flush_o   <= 1'b0;
      sel_o     <= 1'b0;
      mode_o    <= '0;
    end else begin
      flush_o <= 1'b0;
      sel_o   <= 1'b0;
      if (dma_vld_o && dma_rdy_i) dma_vld_o <= 1'b0;
      if (pop_o) begin
        unique case (head_i.typ)
          TYP_CMD: begin
            dma_vld_o <= 1'b1;
            dma_src_o <= head_i.buf_addr;
            dma_dst_o <= head_i.ident;
          end
          TYP_BCAST: flush_o <= (head_i.op == OP_FLUSH);
          TYP_DIRECT: begin
            if (head_i.op == OP_FLUSH) flush_o <= 1'b1;
            if (head_i.op == OP_SELECT) begin
              sel_o  <= 1'b1;
              mode_o <= head_i.info;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tagring_slave.sv
module tagring_slave
  import tagring_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [6:0]   node_id_i,
  input  logic         tag_vld_i,
  input  logic [63:0]  tag_i,
  output logic         out_vld_o,
  output logic [63:0]  out_tag_o,
  input  logic         msg_req_i,
  input  logic [2:0]   msg_op_i,
  input  logic [6:0]   msg_info_i,
  output logic         msg_ack_o,
  input  logic         dma_busy_i,
  output logic         dma_vld_o,
  input  logic         dma_rdy_i,
  output logic [10:0]  dma_src_o,
  output logic [11:0]  dma_dst_o,
  output logic         flush_o,
  output logic         sel_o,
  output logic [6:0]   mode_o
);
  tag_t in_tag, fwd_tag, head_tag;
  logic push, ins, fifo_full, fifo_empty, pop;
  logic [TAG_W-1:0] head_raw;

  assign in_tag   = tag_t'(tag_i);
  assign head_tag = tag_t'(head_raw);

  tagring_classify i_classify (
    .tag_i       (in_tag),
    .node_id_i   (node_id_i),
    .fifo_full_i (fifo_full),
    .dma_busy_i  (dma_busy_i),
    .msg_req_i   (msg_req_i),
    .msg_op_i    (msg_op_i),
    .msg_info_i  (msg_info_i),
    .fwd_o       (fwd_tag),
    .push_o      (push),
    .ins_o       (ins)
  );

  tagring_fifo #(.W(TAG_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tag_vld_i && push),
    .data_i  (tag_i),
    .pop_i   (pop),
    .head_o  (head_raw),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  tagring_exec i_exec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .head_i    (head_tag),
    .empty_i   (fifo_empty),
    .pop_o     (pop),
    .dma_vld_o (dma_vld_o),
    .dma_rdy_i (dma_rdy_i),
    .dma_src_o (dma_src_o),
    .dma_dst_o (dma_dst_o),
    .flush_o   (flush_o),
    .sel_o     (sel_o),
    .mode_o    (mode_o)
  );

  // bypass register: one-cycle forward
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o <= 1'b0;
      out_tag_o <= '0;
      msg_ack_o <= 1'b0;
    end else begin
      out_vld_o <= tag_vld_i;
      msg_ack_o <= tag_vld_i && ins;
      if (tag_vld_i) out_tag_o <= fwd_tag;
    end
  end
endmodule

// File: rtl/tagring_slave_chk.sv
module tagring_slave_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [6:0]  node_id_i,
  input logic        tag_vld_i,
  input logic [63:0] tag_i,
  input logic        out_vld_o,
  input logic [63:0] out_tag_o,
  input logic        msg_req_i,
  input logic [2:0]  msg_op_i,
  input logic [6:0]  msg_info_i,
  input logic        msg_ack_o,
  input logic        dma_busy_i,
  input logic        dma_vld_o,
  input logic        dma_rdy_i,
  input logic [10:0] dma_src_o,
  input logic [11:0] dma_dst_o,
  input logic        flush_o,
  input logic        sel_o,
  input logic [6:0]  mode_o
);
  // R1
  fwd_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_vld_i |=> out_vld_o);
  // R1
  fwd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tag_vld_i |=> !out_vld_o);
  // R2
  sched_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_vld_i && tag_i[63:62] == 2'b01 |=> out_tag_o == $past(tag_i));
  // R5
  busy_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_vld_i && tag_i[63:60] == 4'b1000 && dma_busy_i |=> out_tag_o == $past(tag_i));
  // R3
  ack_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_vld_i && msg_req_i && tag_i[63:62] == 2'b00 |=>
      msg_ack_o && out_tag_o[63:60] == 4'b0111 && out_tag_o[23:17] == $past(node_id_i));
  // R6
  dma_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_vld_o && !dma_rdy_i |=> dma_vld_o && $stable(dma_src_o) && $stable(dma_dst_o));
endmodule

bind tagring_slave tagring_slave_chk i_chk (.*);

// File: tb/test_tagring_slave.sv
module test_tagring_slave;
  localparam int DEPTH = 4;
  localparam logic [6:0] NODE = 7'h15;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tag_vld_i = 1'b0;
  logic [63:0] tag_i = '0;
  logic msg_req_i = 1'b0;
  logic [2:0] msg_op_i = '0;
  logic [6:0] msg_info_i = '0;
  logic dma_busy_i = 1'b0;
  logic dma_rdy_i = 1'b0;
  logic out_vld_o, msg_ack_o, dma_vld_o, flush_o, sel_o;
  logic [63:0] out_tag_o;
  logic [10:0] dma_src_o;
  logic [11:0] dma_dst_o;
  logic [6:0] mode_o;

  int total = 0;
  int fails = 0;
  logic [31:0] evq[$];

  always #10 clk = ~clk;

  tagring_slave #(.FIFO_DEPTH(DEPTH)) i_tagring_slave (
    .clk_i(clk), .rst_ni(rst_ni), .node_id_i(NODE),
    .tag_vld_i(tag_vld_i), .tag_i(tag_i),
    .out_vld_o(out_vld_o), .out_tag_o(out_tag_o),
    .msg_req_i(msg_req_i), .msg_op_i(msg_op_i), .msg_info_i(msg_info_i),
    .msg_ack_o(msg_ack_o), .dma_busy_i(dma_busy_i),
    .dma_vld_o(dma_vld_o), .dma_rdy_i(dma_rdy_i),
    .dma_src_o(dma_src_o), .dma_dst_o(dma_dst_o),
    .flush_o(flush_o), .sel_o(sel_o), .mode_o(mode_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  function automatic logic [6:0] f_chk(input logic [63:0] t);
    logic [6:0] c = '0;
    for (int i = 7; i < 64; i++) c[(i-7)%7] ^= t[i];
    return c;
  endfunction

  function automatic logic [63:0] f_fwd(input logic [63:0] t, input bit busy,
                                        input bit full, input bit req,
                                        input logic [2:0] op, input logic [6:0] info);
    logic [63:0] r = t;
    if (t[63:62] == 2'b00 && req) begin
      r = '0;
      r[63:60] = 4'b0111;
      r[59:57] = op;
      r[23:17] = NODE;
      r[16:10] = info;
      r[6:0]   = f_chk(r);
    end else if (t[63:60] == 4'b1000 && !busy && !full) begin
      r[30:24] = t[30:24] + 7'd1;
      r[6:0]   = f_chk(r);
    end
    return r;
  endfunction

  function automatic logic [63:0] mk_cmd(input logic [10:0] a, input logic [11:0] d);
    logic [63:0] t = {$urandom, $urandom};
    t[63:60] = 4'b1000;
    t[53:43] = a;
    t[42:31] = d;
    return t;
  endfunction

  task automatic send_check(input logic [63:0] t, input bit full, input string req);
    logic [63:0] e;
    tag_vld_i = 1'b1;
    tag_i = t;
    e = f_fwd(t, dma_busy_i, full, msg_req_i, msg_op_i, msg_info_i);
    tick();
    tag_vld_i = 1'b0;
    check(out_vld_o === 1'b1, "R1", "out_vld", {63'd0, out_vld_o}, 64'd1);
    check(out_tag_o === e, req, "forwarded tag", out_tag_o, e);
  endtask

  // compare exec outputs with the predicted action queue (dma_rdy_i high)
  task automatic exec_check();
    logic [31:0] act = '0;
    logic [31:0] exp;
    string rq;
    if (dma_vld_o) act = {2'd1, 7'd0, dma_src_o, dma_dst_o};
    else if (flush_o) act = {2'd2, 30'd0};
    else if (sel_o) act = {2'd3, 23'd0, mode_o};
    if (evq.size() == 0) begin
      check(act == 32'd0, "R9", "spurious action", {32'd0, act}, 64'd0);
    end else begin
      exp = evq.pop_front();
      rq = (exp[31:30] == 2'd1) ? "R6" : (exp[31:30] == 2'd2) ? "R7" : "R8";
      check(act == exp, rq, "action (R9 order)", {32'd0, act}, {32'd0, exp});
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    logic [63:0] c0;
    logic [63:0] cq[DEPTH];
    logic [63:0] t, e;
    bit vld;
    void'($urandom(32'h5eed_1234));
    repeat (3) tick();
    // R1 reset state
    check(out_vld_o === 1'b0, "R1", "reset out_vld", {63'd0, out_vld_o}, 0);
    check(dma_vld_o === 1'b0 && flush_o === 1'b0 && sel_o === 1'b0 && msg_ack_o === 1'b0,
          "R6", "reset outputs", {60'd0, dma_vld_o, flush_o, sel_o, msg_ack_o}, 0);
    rst_ni = 1'b1;
    tick();

    // directed: engine not ready, fill the queue
    dma_rdy_i = 1'b0;
    c0 = mk_cmd(11'h123, 12'habc);
    send_check(c0, 1'b0, "R4");
    tick();
    check(dma_vld_o === 1'b1 && dma_src_o === 11'h123 && dma_dst_o === 12'habc, "R6",
          "descriptor", {29'd0, dma_vld_o, 11'd0, dma_src_o, dma_dst_o}, {29'd0, 1'b1, 11'd0, 11'h123, 12'habc});
    for (int i = 0; i < DEPTH; i++) begin
      cq[i] = mk_cmd(11'(i + 5), 12'(i + 100));
      send_check(cq[i], 1'b0, "R4");
    end
    send_check(mk_cmd(11'h7ff, 12'hfff), 1'b1, "R5");  // queue full: unchanged
    tick();
    check(dma_vld_o === 1'b1 && dma_src_o === 11'h123, "R6", "held descriptor",
          {53'd0, dma_src_o}, {53'd0, 11'h123});
    dma_rdy_i = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      tick();
      check(dma_vld_o === 1'b1 && dma_src_o === cq[i][53:43] && dma_dst_o === cq[i][42:31],
            "R9", "drain order", {41'd0, dma_src_o, dma_dst_o}, {41'd0, cq[i][53:43], cq[i][42:31]});
    end
    tick();
    check(dma_vld_o === 1'b0, "R5", "refused cmd not loaded", {63'd0, dma_vld_o}, 0);

    // directed: busy engine refuses
    dma_busy_i = 1'b1;
    send_check(mk_cmd(11'h055, 12'h066), 1'b0, "R5");
    tick();
    check(dma_vld_o === 1'b0, "R5", "busy no dma", {63'd0, dma_vld_o}, 0);
    dma_busy_i = 1'b0;
    tick();

    // randomized mix
    for (int n = 0; n < 4000; n++) begin
      vld = ($urandom % 4) != 0;
      dma_busy_i = ($urandom % 3) == 0;
      if (!msg_req_i && ($urandom % 5) == 0) begin
        msg_req_i = 1'b1;
        msg_op_i = 3'($urandom);
        msg_info_i = 7'($urandom);
      end
      t = {$urandom, $urandom};
      case ($urandom % 3)
        0: t[59:57] = 3'b000;
        1: t[59:57] = 3'b100;
        default: t[59:57] = 3'b010;
      endcase
      if ($urandom % 2) t[37:31] = NODE;
      tag_vld_i = vld;
      tag_i = t;
      e = f_fwd(t, dma_busy_i, 1'b0, msg_req_i, msg_op_i, msg_info_i);
      tick();
      check(out_vld_o === vld, "R1", "out_vld", {63'd0, out_vld_o}, {63'd0, vld});
      if (vld) begin
        case (t[63:62])
          2'b00: check(out_tag_o === e, "R3", "free slot", out_tag_o, e);
          2'b10: check(out_tag_o === e, (t[61:60] == 2'b00) ? "R4" : "R1", "valid tag", out_tag_o, e);
          default: check(out_tag_o === e, "R2", "pass through", out_tag_o, e);
        endcase
      end
      check(msg_ack_o === (vld && msg_req_i && t[63:62] == 2'b00), "R3", "ack",
            {63'd0, msg_ack_o}, {63'd0, vld && msg_req_i && t[63:62] == 2'b00});
      if (msg_ack_o) msg_req_i = 1'b0;
      exec_check();
      if (vld && t[63:62] == 2'b10) begin
        if (t[61:60] == 2'b00 && !dma_busy_i) evq.push_back({2'd1, 7'd0, t[53:43], t[42:31]});
        if (t[61:60] == 2'b01 && t[59:57] == 3'b100) evq.push_back({2'd2, 30'd0});
        if (t[61:60] == 2'b10 && t[37:31] == NODE) begin
          if (t[59:57] == 3'b100) evq.push_back({2'd2, 30'd0});
          if (t[59:57] == 3'b000) evq.push_back({2'd3, 23'd0, t[16:10]});
        end
      end
    end
    tag_vld_i = 1'b0;
    tick();
    exec_check();
    check(evq.size() == 0, "R9", "all actions seen", 64'(evq.size()), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule